// File: doc/BRIEF.md
# Divider Setting Port for a Clock Synthesizer

This block stores the feedback-divider value (M) and the output-divider value (N) that a clock synthesizer runs with. It also drives a single test pin for debugging. Settings arrive in one of two ways. The first is a parallel bus, which is transparent while its active-low load strobe is low and captured when that strobe rises. The second is a serial frame, shifted in on a slow shift clock and committed by a separate serial load strobe.

The serial frame is 14 bits long and also carries two test-select bits. These bits choose what the test pin shows: a constant low, the incoming serial data, the feedback-divider output or the synthesized clock. The test pin is forced low while the parallel strobe is low.

All strobes, the shift clock and the serial data are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and its edges are detected from the synchronized samples. A range flag warns when the active M lies outside the range in which the loop can lock.

Top module: `divcfg_port`

## Requirements
- R1: After reset the active settings are M = 200, N = 0 and test select = 00, with the shift register cleared. After reset the test pin and the range flag are both low.
- R2: While `par_load_n` is low, `m_val` and `n_val` follow `par_m` and `par_n`, and a new bus value appears within a few system clocks.
- R3: When `par_load_n` rises, the bus value is captured. After the capture, further changes on `par_m`/`par_n` have no effect until the strobe falls again or a serial update occurs.
- R4: The shift register takes one bit from `ser_dat` on each rising edge of `ser_clk`, and only while `par_load_n` is high. Shift-clock edges and serial load pulses that arrive while `par_load_n` is low leave the shift register and the settings unchanged.
- R5: In the serial frame, the first bit shifted in is test bit 1, then test bit 0, then N bits 2 down to 0, then M bits 8 down to 0. M bit 0 is shifted in last. After a full frame, bit 13 of the register holds test bit 1 and bits 8..0 hold M.
- R6: A rising edge of `ser_load` copies the shift register to M, N and the test select. After `ser_load` falls, the settings stay latched while new bits are shifted in.
- R7: While `ser_load` is held high, every shift-clock edge copies the freshly shifted register contents straight into M, N and the test select.
- R8: With `par_load_n` high, test select 00 drives `test_pin` low, 01 drives the synchronized serial data, 10 drives `fb_div_in` and 11 drives `clk_out_in`.
- R9: `test_pin` is low whenever `par_load_n` is low, whatever the test select.
- R10: `m_bad` is high exactly when the active M is below 125 or above 350. Both 125 and 350 count as valid.
- R11: When a parallel capture edge and a serial load edge are seen in the same system clock cycle, the parallel value wins. In that case the test select is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every pin |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| par_load_n | input | 1 | Active-low parallel load strobe (asynchronous) |
| par_m | input | 9 | Parallel M value |
| par_n | input | 3 | Parallel N value |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data (asynchronous) |
| ser_load | input | 1 | Serial load strobe (asynchronous) |
| fb_div_in | input | 1 | Feedback-divider output from the synthesizer |
| clk_out_in | input | 1 | Synthesized output clock |
| m_val | output | 9 | Active M setting |
| n_val | output | 3 | Active N setting |
| test_sel | output | 2 | Active test-select bits |
| test_pin | output | 1 | Debug test output |
| m_bad | output | 1 | Active M lies outside the lockable range |

## Verification
A wrong setting register is visible at once on `m_val`, `n_val` or `test_sel`, and about three system clocks after the pin edge that should have moved it. A corrupted or misordered shift register stays hidden until the next serial load edge, or until the next shift edge while `ser_load` is held high. For that reason the bench commits every frame it shifts and checks each field against its position in the frame. Errors in priority or in ignoring inputs show up only as a stale or overwritten setting after a later commit, so each such scenario ends with a commit and a readback at the ports.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  localparam int CFG_M_W   = 9;
  localparam int CFG_N_W   = 3;
  localparam int CFG_T_W   = 2;
  localparam int CFG_M_MIN = 125;
  localparam int CFG_M_MAX = 350;
  localparam int CFG_M_RST = 200;

  typedef enum logic [1:0] {
    TST_LOW   = 2'b00,
    TST_SDATA = 2'b01,
    TST_FB    = 2'b10,
    TST_CLK   = 2'b11
  } tst_sel_e;
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
  parameter int            W       = 4,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] stg_q;
    logic [1:0] stg_d;
    always_comb stg_d = {stg_q[0], d[i]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= {2{RST_VAL[i]}};
      else        stg_q <= stg_d;
    end
    assign q[i] = stg_q[1];
  end
endmodule

// File: rtl/divcfg_shreg.sv
module divcfg_shreg #(
  parameter int FW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          din,
  output logic [FW-1:0] q,
  output logic [FW-1:0] q_nxt
);
  always_comb begin
    q_nxt = q;
    if (shift_en) q_nxt = {q[FW-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (shift_en) q <= q_nxt;
  end
endmodule

// File: rtl/divcfg_settings.sv
module divcfg_settings #(
  parameter int             M_W     = 9,
  parameter int             N_W     = 3,
  parameter int             T_W     = 2,
  parameter int             FW      = T_W + N_W + M_W,
  parameter logic [M_W-1:0] M_RSTV  = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_mode,
  input  logic           par_cap,
  input  logic           ser_upd,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic [FW-1:0]  frame,
  output logic [M_W-1:0] m_q,
  output logic [N_W-1:0] n_q,
  output logic [T_W-1:0] t_q
);
  logic [M_W-1:0] m_d;
  logic [N_W-1:0] n_d;
  logic [T_W-1:0] t_d;
  logic           en;

  always_comb begin
    m_d = m_q;
    n_d = n_q;
    t_d = t_q;
    en  = 1'b0;
    if (par_mode || par_cap) begin
      m_d = par_m;
      n_d = par_n;
      en  = 1'b1;
    end else if (ser_upd) begin
      m_d = frame[M_W-1:0];
      n_d = frame[M_W+N_W-1:M_W];
      t_d = frame[FW-1:FW-T_W];
      en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= M_RSTV;
      n_q <= '0;
      t_q <= '0;
    end else if (en) begin
      m_q <= m_d;
      n_q <= n_d;
      t_q <= t_d;
    end
  end
endmodule

// File: rtl/divcfg_testmux.sv
module divcfg_testmux
  import divcfg_pkg::*;
(
  input  logic       par_mode,
  input  logic [1:0] sel,
  input  logic       sdata,
  input  logic       fb_div,
  input  logic       clk_out,
  output logic       pin
);
  always_comb begin
    pin = 1'b0;
    if (!par_mode) begin
      case (tst_sel_e'(sel))
        TST_SDATA: pin = sdata;
        TST_FB:    pin = fb_div;
        TST_CLK:   pin = clk_out;
        default:   pin = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/divcfg_port.sv
module divcfg_port
  import divcfg_pkg::*;
#(
  parameter int M_W   = CFG_M_W,
  parameter int N_W   = CFG_N_W,
  parameter int M_MIN = CFG_M_MIN,
  parameter int M_MAX = CFG_M_MAX,
  parameter int M_RST = CFG_M_RST
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_load_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_load,
  input  logic           fb_div_in,
  input  logic           clk_out_in,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_val,
  output logic [1:0]     test_sel,
  output logic           test_pin,
  output logic           m_bad
);
  localparam int             T_W    = CFG_T_W;
  localparam int             FW     = T_W + N_W + M_W;
  localparam logic [M_W-1:0] M_LO   = M_W'(M_MIN);
  localparam logic [M_W-1:0] M_HI   = M_W'(M_MAX);
  localparam logic [M_W-1:0] M_RSTV = M_W'(M_RST);

  // synchronized pins: {par_load_n, ser_load, ser_clk, ser_dat}
  logic [3:0] raw_pins, syn_pins;
  logic       pl_s, sl_s, sc_s, sd_s;

  assign raw_pins = {par_load_n, ser_load, ser_clk, ser_dat};

  divcfg_sync #(.W(4), .RST_VAL(4'b1000)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_pins),
    .q     (syn_pins)
  );

  assign {pl_s, sl_s, sc_s, sd_s} = syn_pins;

  // previous samples for edge detection: {pl, sl, sc}
  logic [2:0] prev_q, prev_d;
  always_comb prev_d = {pl_s, sl_s, sc_s};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 3'b100;
    else        prev_q <= prev_d;
  end

  logic par_mode, pl_rise, sl_rise, sc_rise, shift_en, ser_upd;
  assign par_mode = ~pl_s;
  assign pl_rise  = pl_s & ~prev_q[2];
  assign sl_rise  = sl_s & ~prev_q[1];
  assign sc_rise  = sc_s & ~prev_q[0];
  assign shift_en = pl_s & sc_rise;
  assign ser_upd  = pl_s & sl_s & (sl_rise | sc_rise);

  logic [FW-1:0] sr_q, sr_nxt;

  divcfg_shreg #(.FW(FW)) i_shreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .din      (sd_s),
    .q        (sr_q),
    .q_nxt    (sr_nxt)
  );

  logic [T_W-1:0] t_q;

  divcfg_settings #(
    .M_W    (M_W),
    .N_W    (N_W),
    .T_W    (T_W),
    .FW     (FW),
    .M_RSTV (M_RSTV)
  ) i_settings (
    .clk      (clk),
    .rst_n    (rst_n),
    .par_mode (par_mode),
    .par_cap  (pl_rise),
    .ser_upd  (ser_upd),
    .par_m    (par_m),
    .par_n    (par_n),
    .frame    (sr_nxt),
    .m_q      (m_val),
    .n_q      (n_val),
    .t_q      (t_q)
  );

  assign test_sel = t_q;

  divcfg_testmux i_tmux (
    .par_mode (par_mode),
    .sel      (t_q),
    .sdata    (sd_s),
    .fb_div   (fb_div_in),
    .clk_out  (clk_out_in),
    .pin      (test_pin)
  );

  assign m_bad = (m_val < M_LO) || (m_val > M_HI);

  logic unused_sr;
  assign unused_sr = ^sr_q;
endmodule

// File: rtl/divcfg_chk.sv
module divcfg_chk #(
  parameter int M_W = 9,
  parameter int N_W = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           par_mode,
  input logic           pl_rise,
  input logic           ser_upd,
  input logic [M_W-1:0] par_m,
  input logic [N_W-1:0] par_n,
  input logic [M_W-1:0] m_val,
  input logic [N_W-1:0] n_val,
  input logic [1:0]     test_sel,
  input logic           test_pin,
  input logic           fb_div_in,
  input logic           clk_out_in
);
  AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode |=> (m_val == $past(par_m)) && (n_val == $past(par_n))); // R2

  AST_SER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && !pl_rise && !ser_upd) |=>
      ($stable(m_val) && $stable(n_val) && $stable(test_sel))); // R6

  AST_PAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_rise && ser_upd) |=>
      ((m_val == $past(par_m)) && $stable(test_sel))); // R11

  AST_TEST_PAR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode |-> !test_pin); // R9

  AST_TEST_FB: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && test_sel == 2'b10) |-> (test_pin == fb_div_in)); // R8

  AST_TEST_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && test_sel == 2'b11) |-> (test_pin == clk_out_in)); // R8
endmodule

bind divcfg_port divcfg_chk #(.M_W(M_W), .N_W(N_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .par_mode   (par_mode),
  .pl_rise    (pl_rise),
  .ser_upd    (ser_upd),
  .par_m      (par_m),
  .par_n      (par_n),
  .m_val      (m_val),
  .n_val      (n_val),
  .test_sel   (test_sel),
  .test_pin   (test_pin),
  .fb_div_in  (fb_div_in),
  .clk_out_in (clk_out_in)
);

// File: tb/test_divcfg_port.sv
`timescale 1ns/1ps
module test_divcfg_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       par_load_n, ser_clk, ser_dat, ser_load, fb_div_in, clk_out_in;
  logic [8:0] par_m;
  logic [2:0] par_n;
  logic [8:0] m_val;
  logic [2:0] n_val;
  logic [1:0] test_sel;
  logic       test_pin, m_bad;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  divcfg_port i_divcfg_port (
    .clk(clk), .rst_n(rst_n), .par_load_n(par_load_n), .par_m(par_m), .par_n(par_n),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_load(ser_load),
    .fb_div_in(fb_div_in), .clk_out_in(clk_out_in),
    .m_val(m_val), .n_val(n_val), .test_sel(test_sel), .test_pin(test_pin), .m_bad(m_bad)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ser_bit(input logic b);
    ser_dat = b; tick(4);
    ser_clk = 1'b1; tick(4);
    ser_clk = 1'b0; tick(4);
  endtask

  task automatic ser_frame(input logic [1:0] t, input logic [2:0] n, input logic [8:0] m);
    logic [13:0] f;
    f = {t, n, m};
    for (int i = 13; i >= 0; i--) ser_bit(f[i]);
  endtask

  task automatic ser_strobe();
    ser_load = 1'b1; tick(6);
    ser_load = 1'b0; tick(6);
  endtask

  task automatic t_reset();
    check("R1 m", int'(m_val), 200);
    check("R1 n", int'(n_val), 0);
    check("R1 tsel", int'(test_sel), 0);
    check("R1 pin", int'(test_pin), 0);
    check("R1 bad", int'(m_bad), 0);
  endtask

  task automatic t_parallel();
    par_m = 9'd300; par_n = 3'd5; par_load_n = 1'b0; tick(6);
    check("R2 m", int'(m_val), 300);
    check("R2 n", int'(n_val), 5);
    par_m = 9'd150; tick(3);
    check("R2 follow", int'(m_val), 150);
    par_load_n = 1'b1; tick(6);
    par_m = 9'd77; par_n = 3'd2; tick(6);
    check("R3 held m", int'(m_val), 150);
    check("R3 held n", int'(n_val), 5);
  endtask

  task automatic t_serial();
    ser_frame(2'b00, 3'd3, 9'd333);
    check("R6 no strobe", int'(m_val), 150);
    ser_strobe();
    check("R5 m", int'(m_val), 333);
    check("R5 n", int'(n_val), 3);
    check("R5 t", int'(test_sel), 0);
    ser_frame(2'b00, 3'd6, 9'd130);
    check("R6 latched m", int'(m_val), 333);
    check("R6 latched n", int'(n_val), 3);
    // T1 must land in test_sel[1], M0 last
    ser_frame(2'b10, 3'd1, 9'd1);
    ser_strobe();
    check("R5 t order", int'(test_sel), 2);
    check("R5 m0 last", int'(m_val), 1);
    ser_frame(2'b00, 3'd6, 9'd130);
  endtask

  task automatic t_ignore_par();
    par_m = 9'd250; par_n = 3'd1; par_load_n = 1'b0; tick(6);
    ser_frame(2'b00, 3'd7, 9'd400);
    ser_strobe();
    check("R4 par mode m", int'(m_val), 250);
    par_load_n = 1'b1; tick(6);
    check("R3 capture", int'(m_val), 250);
    ser_strobe();
    check("R4 sr kept m", int'(m_val), 130);
    check("R4 sr kept n", int'(n_val), 6);
  endtask

  task automatic t_transparent();
    logic [13:0] f, nf;
    f  = {2'b00, 3'd2, 9'd345};
    nf = {f[12:0], 1'b1};
    ser_load = 1'b1; tick(6);
    ser_frame(f[13:12], f[11:9], f[8:0]);
    check("R7 m", int'(m_val), 345);
    check("R7 n", int'(n_val), 2);
    ser_bit(1'b1);
    check("R7 step m", int'(m_val), int'(nf[8:0]));
    check("R7 step n", int'(n_val), int'(nf[11:9]));
    check("R7 step t", int'(test_sel), int'(nf[13:12]));
    ser_load = 1'b0; tick(6);
  endtask

  task automatic t_test_mux();
    ser_frame(2'b01, 3'd0, 9'd200); ser_strobe();
    ser_dat = 1'b1; tick(4);
    check("R8 sdata hi", int'(test_pin), 1);
    ser_dat = 1'b0; tick(4);
    check("R8 sdata lo", int'(test_pin), 0);
    ser_frame(2'b10, 3'd0, 9'd200); ser_strobe();
    fb_div_in = 1'b1; #1;
    check("R8 fb hi", int'(test_pin), 1);
    fb_div_in = 1'b0; #1;
    check("R8 fb lo", int'(test_pin), 0);
    ser_frame(2'b11, 3'd0, 9'd200); ser_strobe();
    clk_out_in = 1'b1; #1;
    check("R8 clk hi", int'(test_pin), 1);
    par_m = 9'd200; par_n = 3'd0; par_load_n = 1'b0; tick(6);
    check("R9 par low", int'(test_pin), 0);
    par_load_n = 1'b1; tick(6);
    check("R9 restore", int'(test_pin), 1);
    clk_out_in = 1'b0; #1;
    check("R8 clk lo", int'(test_pin), 0);
    fb_div_in = 1'b1; clk_out_in = 1'b1;
    ser_frame(2'b00, 3'd0, 9'd200); ser_strobe();
    check("R8 const low", int'(test_pin), 0);
    fb_div_in = 1'b0; clk_out_in = 1'b0;
  endtask

  task automatic t_range();
    par_load_n = 1'b0;
    par_m = 9'd124; tick(4); check("R10 124", int'(m_bad), 1);
    par_m = 9'd125; tick(4); check("R10 125", int'(m_bad), 0);
    par_m = 9'd350; tick(4); check("R10 350", int'(m_bad), 0);
    par_m = 9'd351; tick(4); check("R10 351", int'(m_bad), 1);
    par_load_n = 1'b1; tick(6);
  endtask

  task automatic t_prio();
    ser_frame(2'b01, 3'd4, 9'd180);
    par_m = 9'd222; par_n = 3'd7; par_load_n = 1'b0; tick(6);
    par_load_n = 1'b1; ser_load = 1'b1; tick(6);
    check("R11 m", int'(m_val), 222);
    check("R11 n", int'(n_val), 7);
    check("R11 t", int'(test_sel), 0);
    ser_load = 1'b0; tick(6);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; par_load_n = 1'b1; par_m = '0; par_n = '0;
    ser_clk = 1'b0; ser_dat = 1'b0; ser_load = 1'b0;
    fb_div_in = 1'b0; clk_out_in = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(6);
    t_reset();
    t_parallel();
    t_serial();
    t_ignore_par();
    t_transparent();
    t_test_mux();
    t_range();
    t_prio();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule